// File: doc/BRIEF.md
# Address Register Read-After-Write Stall Detector

This hazard unit sits between the execute stage and the prefetch stage of a two-stage core whose working (W) registers also appear in data memory. Every cycle it looks at the destination operand of the executing instruction and at the source operand of the prefetched instruction. If the prefetched instruction would build its source address from a W register whose value is still being written, the unit requests a single extra cycle so that the address is formed from the updated value.

There are two ways a W register can be written. The first is by name: a direct-mode destination, or the pointer update of an indirect destination with pre/post modification. The second is by address: an indirect store whose effective address lands on the register's memory-mapped slot. Register n occupies the 16-bit word at byte address `WREG_BASE + 2*n`, so with the default base W2 sits at 0x0004. A source operand used in direct mode never needs an address, so it never stalls. Within one instruction, a destination that names its own source register uses the old value and ignores any offset. That case stays local to one instruction and does not involve this unit.

The stall strobe is registered. It reflects the operand pair presented at the previous clock edge, and it is forced low in the cycle after a stall, so one pair costs at most one cycle.

Top module: `wreg_raw_guard`

## Requirements
- R1: While `rst` is high at a clock edge, `stall` is low after that edge. It stays low until a valid hazard pair is sampled.
- R2: `stall` is high in the cycle after an edge only if both `exe_valid` and `pre_valid` were high at that edge.
- R3: Mode codes are 2'b00 none, 2'b01 direct, 2'b10 indirect, and 2'b11 indirect with pre/post modification. A source mode of 2'b00 or 2'b01 never produces a stall.
- R4: A destination in direct mode (01) that names the same register as an indirect source (10 or 11) produces a stall.
- R5: A destination in mode 10 or 11 produces a stall for an indirect source when its effective address, with bit 0 ignored, equals the source register's mapped word `WREG_BASE + 2*n`.
- R6: A destination in mode 11 that names the same register as an indirect source produces a stall, whether or not its effective address aliases.
- R7: A destination in mode 10 (plain indirect) whose effective address does not alias the source register produces no stall, even when its register field matches. A destination in mode 00 never produces a stall.
- R8: In the cycle after `stall` is high, `stall` is low, whatever the inputs.
- R9: The alias comparison uses every effective-address bit above bit 0. An address that differs from the mapped slot only in its upper bits does not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exe_valid | input | 1 | Executing instruction is valid |
| exe_dst_mode | input | 2 | Destination addressing mode of the executing instruction |
| exe_dst_reg | input | IDX_W (4) | W register named by the destination |
| exe_dst_ea | input | ADDR_W (16) | Byte effective address written by the destination |
| pre_valid | input | 1 | Prefetched instruction is valid |
| pre_src_mode | input | 2 | Source addressing mode of the prefetched instruction |
| pre_src_reg | input | IDX_W (4) | W register named by the source |
| stall | output | 1 | One-cycle hold request for the prefetched instruction |

## Verification
Two functions can act in the same cycle: detection of a fresh hazard, and suppression of a second stall right after a first one. The bench holds a hazard pair on the inputs across consecutive edges. It then expects the strobe high once and low in the following cycle, even though the detection logic still sees a hazard. A second collision happens when a destination both names the source register and aliases its mapped slot. The bench sweeps these overlapping cases and judges each one against a reference function derived from the rules.

// File: rtl/wraw_pkg.sv
package wraw_pkg;

  // Operand addressing mode, 2-bit code shared by source and destination
  typedef enum logic [1:0] {
    AM_NONE    = 2'b00,
    AM_DIRECT  = 2'b01,
    AM_IND     = 2'b10,
    AM_IND_MOD = 2'b11
  } amode_e;

  // An operand forms an address from its W register when the mode is indirect
  function automatic logic uses_pointer(input amode_e m);
    return (m == AM_IND) || (m == AM_IND_MOD);
  endfunction

endpackage

// File: rtl/wraw_alias_decode.sv
// Decodes a destination effective address into a per-register hit vector:
// bit n is set when the address falls in W register n's mapped word.
module wraw_alias_decode #(
  parameter int NUM_WREGS = 16,
  parameter int ADDR_W    = 16,
  parameter int WREG_BASE = 0
) (
  input  logic [ADDR_W-1:0]    ea,
  output logic [NUM_WREGS-1:0] hit
);

  for (genvar i = 0; i < NUM_WREGS; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(WREG_BASE + 2 * i);
    // word compare: either byte of the register counts
    assign hit[i] = (ea[ADDR_W-1:1] == SLOT[ADDR_W-1:1]);
  end

endmodule

// File: rtl/wraw_hazard_rules.sv
// Combinational stall rules for one destination/source operand pair.
module wraw_hazard_rules
  import wraw_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             both_valid,
  input  amode_e           dst_mode,
  input  logic [IDX_W-1:0] dst_reg,
  input  amode_e           src_mode,
  input  logic [IDX_W-1:0] src_reg,
  input  logic             alias_hit,
  output logic             hazard
);

  logic same_reg;
  logic by_name;
  logic by_addr;

  always_comb begin
    same_reg = (dst_reg == src_reg);
    // register written by name: direct result or pointer update
    by_name  = same_reg && ((dst_mode == AM_DIRECT) || (dst_mode == AM_IND_MOD));
    // register written through its memory-mapped slot
    by_addr  = alias_hit && uses_pointer(dst_mode);
    hazard   = both_valid && uses_pointer(src_mode) && (by_name || by_addr);
  end

endmodule

// File: rtl/wreg_raw_guard.sv
module wreg_raw_guard
  import wraw_pkg::*;
#(
  parameter int NUM_WREGS = 16,
  parameter int ADDR_W    = 16,
  parameter int WREG_BASE = 0,
  localparam int IDX_W    = $clog2(NUM_WREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exe_valid,
  input  logic [1:0]        exe_dst_mode,
  input  logic [IDX_W-1:0]  exe_dst_reg,
  input  logic [ADDR_W-1:0] exe_dst_ea,
  input  logic              pre_valid,
  input  logic [1:0]        pre_src_mode,
  input  logic [IDX_W-1:0]  pre_src_reg,
  output logic              stall
);

  logic [NUM_WREGS-1:0] alias_vec;
  logic                 alias_sel;
  logic                 hazard;

  wraw_alias_decode #(
    .NUM_WREGS(NUM_WREGS),
    .ADDR_W   (ADDR_W),
    .WREG_BASE(WREG_BASE)
  ) u_alias (
    .ea (exe_dst_ea),
    .hit(alias_vec)
  );

  assign alias_sel = alias_vec[pre_src_reg];

  wraw_hazard_rules #(
    .IDX_W(IDX_W)
  ) u_rules (
    .both_valid(exe_valid && pre_valid),
    .dst_mode  (amode_e'(exe_dst_mode)),
    .dst_reg   (exe_dst_reg),
    .src_mode  (amode_e'(pre_src_mode)),
    .src_reg   (pre_src_reg),
    .alias_hit (alias_sel),
    .hazard    (hazard)
  );

  // Registered strobe; a stall cycle always releases the next one
  always_ff @(posedge clk) begin
    if (rst) stall <= 1'b0;
    else     stall <= hazard && !stall;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> !stall);

  p_valid_r2: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(exe_valid && pre_valid));

  p_direct_src_r3: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(pre_src_mode[1]));

  p_one_slot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alias_vec));

  p_single_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

endmodule

// File: tb/wreg_raw_guard_test.sv
module wreg_raw_guard_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        exe_valid;
  logic [1:0]  exe_dst_mode;
  logic [3:0]  exe_dst_reg;
  logic [15:0] exe_dst_ea;
  logic        pre_valid;
  logic [1:0]  pre_src_mode;
  logic [3:0]  pre_src_reg;
  logic        stall;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  wreg_raw_guard uut (
    .clk(clk), .rst(rst),
    .exe_valid(exe_valid), .exe_dst_mode(exe_dst_mode),
    .exe_dst_reg(exe_dst_reg), .exe_dst_ea(exe_dst_ea),
    .pre_valid(pre_valid), .pre_src_mode(pre_src_mode),
    .pre_src_reg(pre_src_reg), .stall(stall)
  );

  // {dst_mode, dst_reg, dst_ea, src_mode, src_reg, expected}
  localparam int NTBL = 14;
  localparam logic [28:0] TBL [NTBL] = '{
    {2'b01, 4'd2, 16'h0000, 2'b01, 4'd2, 1'b0},  // R3 direct/direct
    {2'b10, 4'd3, 16'h0004, 2'b01, 4'd2, 1'b0},  // R3 alias but direct src
    {2'b11, 4'd2, 16'h0004, 2'b00, 4'd2, 1'b0},  // R3 no source
    {2'b01, 4'd2, 16'h0000, 2'b10, 4'd2, 1'b1},  // R4 direct -> [W2]
    {2'b01, 4'd2, 16'h0000, 2'b11, 4'd2, 1'b1},  // R4 direct -> [W2++]
    {2'b01, 4'd3, 16'h0000, 2'b10, 4'd2, 1'b0},  // R4 other register
    {2'b10, 4'd7, 16'h0004, 2'b10, 4'd2, 1'b1},  // R5 store to W2 slot
    {2'b10, 4'd7, 16'h0005, 2'b11, 4'd2, 1'b1},  // R5 odd byte of W2
    {2'b11, 4'd7, 16'h001E, 2'b10, 4'd15, 1'b1}, // R5 last slot, mod dest
    {2'b11, 4'd2, 16'h0400, 2'b10, 4'd2, 1'b1},  // R6 [W2++] -> [W2]
    {2'b11, 4'd2, 16'h0400, 2'b11, 4'd2, 1'b1},  // R6 [W2++] -> [W2++]
    {2'b10, 4'd2, 16'h0400, 2'b10, 4'd2, 1'b0},  // R7 plain [W2] -> [W2]
    {2'b00, 4'd2, 16'h0004, 2'b10, 4'd2, 1'b0},  // R7 no destination
    {2'b10, 4'd2, 16'h8004, 2'b10, 4'd2, 1'b0}   // R9 upper bits differ
  };

  function automatic logic ref_stall(input logic [1:0] dm, input logic [3:0] dr,
                                     input logic [15:0] dea, input logic [1:0] sm,
                                     input logic [3:0] sr);
    logic name_w, addr_w;
    if (sm == 2'b00 || sm == 2'b01) return 1'b0;
    name_w = (dr == sr) && (dm == 2'b01 || dm == 2'b11);
    addr_w = (dm == 2'b10 || dm == 2'b11) && (dea[15:1] == {11'd0, sr});
    return name_w || addr_w;
  endfunction

  task automatic check(input logic exp, input string req);
    n_checks++;
    if (stall !== exp) begin
      n_fail++;
      $display("FAIL %s: stall=%b expected=%b", req, stall, exp);
    end
  endtask

  task automatic drive(input logic ev, input logic [1:0] dm, input logic [3:0] dr,
                       input logic [15:0] dea, input logic pv,
                       input logic [1:0] sm, input logic [3:0] sr);
    exe_valid = ev; exe_dst_mode = dm; exe_dst_reg = dr; exe_dst_ea = dea;
    pre_valid = pv; pre_src_mode = sm; pre_src_reg = sr;
  endtask

  task automatic idle();
    drive(1'b0, 2'b00, 4'd0, 16'h0000, 1'b0, 2'b00, 4'd0);
    @(negedge clk);
    check(1'b0, "R2 idle");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 2'b01, 4'd2, 16'h0000, 1'b1, 2'b10, 4'd2);  // hazard held in reset
    repeat (3) @(negedge clk);
    check(1'b0, "R1 during reset");
    rst = 1'b0;
    idle();

    // vector table
    for (int i = 0; i < NTBL; i++) begin
      drive(1'b1, TBL[i][28:27], TBL[i][26:23], TBL[i][22:7], 1'b1,
            TBL[i][6:5], TBL[i][4:1]);
      @(negedge clk);
      check(TBL[i][0], "R3-R9 table");
      idle();
    end

    // sweep: every mode pair times four register/address relations
    for (int dm = 0; dm < 4; dm++)
      for (int sm = 0; sm < 4; sm++)
        for (int c = 0; c < 4; c++) begin
          logic [3:0] sr, dr;
          logic [15:0] ea;
          logic exp;
          sr = 4'((c * 5 + dm + 3) % 16);
          case (c)
            0: begin dr = sr;        ea = {11'd0, sr, 1'b0}; end
            1: begin dr = sr;        ea = 16'h0100 + {11'd0, sr, 1'b0}; end
            2: begin dr = sr ^ 4'd1; ea = {11'd0, sr, 1'b1}; end
            default: begin dr = sr ^ 4'd1; ea = {11'd0, sr ^ 4'd2, 1'b0}; end
          endcase
          exp = ref_stall(2'(dm), dr, ea, 2'(sm), sr);
          drive(1'b1, 2'(dm), dr, ea, 1'b1, 2'(sm), sr);
          @(negedge clk);
          check(exp, "R4 R5 R6 R7 sweep");
          idle();
        end

    // R2: either valid low blocks an otherwise hazardous pair
    drive(1'b0, 2'b01, 4'd2, 16'h0000, 1'b1, 2'b10, 4'd2);
    @(negedge clk); check(1'b0, "R2 exe invalid");
    drive(1'b1, 2'b01, 4'd2, 16'h0000, 1'b0, 2'b10, 4'd2);
    @(negedge clk); check(1'b0, "R2 pre invalid");

    // R8: hazard held for two edges stalls once, then releases
    drive(1'b1, 2'b10, 4'd9, 16'h0004, 1'b1, 2'b10, 4'd2);
    @(negedge clk); check(1'b1, "R8 first cycle");
    @(negedge clk); check(1'b0, "R8 released");
    @(negedge clk); check(1'b1, "R8 rearmed");

    // R1: reset cancels a pending stall
    rst = 1'b1;
    @(negedge clk); check(1'b0, "R1 reset mid-hazard");
    rst = 1'b0;
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule